// File: doc/BRIEF.md
# Low-Speed Independent Watchdog

This block is a watchdog timer that runs entirely from its own slow clock (typically a free-running oscillator of around 32 kHz). It keeps counting even if the main system clock stops. A power-of-two prescaler divides that clock, and each prescaler wrap decrements a down-counter. The counter starts from a programmable reload value. Software must deliver refresh requests often enough to put the reload value back into the counter. If the counter ever reaches zero, the block drives a system reset request for a fixed number of watchdog clock cycles. It then reloads the counter and keeps watching.

The prescaler divides by 4·2^code. The timeout is therefore (4·2^code × reload) / f_clk seconds. For example, code 3 with a reload of 1000 at 32 kHz gives one second, and a refresh every 800 ms then never causes a reset. Refresh requests may come from another clock domain. They pass through a synchronizer and an edge detector, so one request gives exactly one reload. Once the watchdog is started it cannot be stopped, except by the asynchronous reset.

Top module: `lswd_watchdog`

## Requirements
- R1: While `arst_ni` is low, `wdt_rst_o` is 0 and `count_o` is 0. After reset and before the first enable, `count_o` follows `reload_i`, one cycle late, and `wdt_rst_o` stays 0.
- R2: The enable is sampled at clock edge E. From then on, `count_o` goes down by one at edges E + k·D, where D = 4·2^`psc_code_i`. So `count_o` still equals the reload value at edge E + D − 1, and equals reload − 1 at edge E + D.
- R3: When the counter reaches zero, `wdt_rst_o` rises on the next edge. Without any refresh, the first assertion appears at edge E + reload·D + 1.
- R4: `wdt_rst_o` stays high for exactly 4 clock cycles. On the edge where it falls, `count_o` takes the value of `reload_i`.
- R5: A refresh request on `refresh_req_i` is taken on its rising level. It reaches the counter through two synchronizer flops. It reloads the counter on the second edge after the edge that first samples it high. Refreshes spaced closer than the timeout never produce a reset.
- R6: A refresh request that is held high produces only one reload. The counter then keeps counting down, even though the request is still high.
- R7: After the enable is sampled high, driving `enable_i` low again has no effect. Timing and reset generation continue unchanged until `arst_ni` is asserted.
- R8: A new `psc_code_i` takes effect only at the next prescaler wrap. The divide period already in progress finishes with the old ratio.
- R9: Asserting `arst_ni` clears `wdt_rst_o` and the counter at once, without waiting for a clock edge, even in the middle of a reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Independent low-speed watchdog clock |
| arst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Start request; captured and held until reset |
| psc_code_i | input | 3 | Prescaler code, divide ratio 4·2^code |
| reload_i | input | 12 | Reload value for the down-counter |
| refresh_req_i | input | 1 | Refresh request level, may come from another clock domain |
| wdt_rst_o | output | 1 | System reset request |
| count_o | output | 12 | Current down-counter value |

## Verification
The bench builds the block with its default parameters: 3-bit prescaler code, 12-bit counter and a 4-cycle reset pulse. It uses small reload values, so every prescaler code from divide-by-4 to divide-by-512 can be swept through a full timeout, with the expected reset edge computed as reload·4·2^code + 1. The same small configuration puts the following within reach of a short run:
- a sweep of reload values at the fastest ratio;
- a prescaler change in the middle of a period;
- a refresh that is held high;
- an asynchronous reset during the reset pulse.

// File: rtl/lswd_pkg.sv
package lswd_pkg;

   // Width of a prescaler counter able to reach 2^(base_shift + 2^code_w - 1)
   function automatic int unsigned psc_cnt_bits(input int unsigned base_shift,
                                                input int unsigned code_w);
      return base_shift + (1 << code_w) - 1;
   endfunction

endpackage

// File: rtl/lswd_sync.sv
module lswd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic req_i,
   output logic pulse_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], req_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign pulse_o = chain_q[STAGES-1] & ~last_q;

   // R6: a request yields a single-cycle pulse
   p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!arst_ni)
      pulse_o |=> !pulse_o);

endmodule

// File: rtl/lswd_prescaler.sv
module lswd_prescaler #(
   parameter int unsigned CODE_W     = 3,
   parameter int unsigned BASE_SHIFT = 2
) (
   input  logic              clk_i,
   input  logic              arst_ni,
   input  logic              run_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              tick_o
);

   localparam int unsigned          PCW      = lswd_pkg::psc_cnt_bits(BASE_SHIFT, CODE_W);
   localparam logic [CODE_W-1:0]    CODE_MAX = '1;

   logic [CODE_W-1:0] code_q;
   logic [PCW-1:0]    cnt_q;
   logic [PCW-1:0]    last_v;

   // terminal value 4*2^code - 1 as an all-ones mask
   always_comb last_v = {PCW{1'b1}} >> (CODE_MAX - code_q);

   assign tick_o = run_i & (cnt_q == last_v);

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         cnt_q  <= '0;
         code_q <= '0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         code_q <= code_i;
      end else if (tick_o) begin
         cnt_q  <= '0;
         code_q <= code_i;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!arst_ni)
      cnt_q <= last_v);

   p_code_wrap_only_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (run_i && $past(run_i) && !$past(tick_o)) |-> $stable(code_q));

endmodule

// File: rtl/lswd_downcnt.sv
module lswd_downcnt #(
   parameter int unsigned CNT_W = 12,
   parameter int unsigned HOLD  = 4
) (
   input  logic             clk_i,
   input  logic             arst_ni,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             refresh_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             fire_o
);

   localparam int unsigned HW = $clog2(HOLD + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [HW-1:0]    hold_q;
   logic             busy;

   assign busy    = (hold_q != '0);
   assign fire_o  = busy;
   assign count_o = cnt_q;

   // priority: pulse in progress > zero detect > refresh > tick
   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         cnt_q  <= '0;
         hold_q <= '0;
      end else if (!run_i) begin
         cnt_q  <= reload_i;
         hold_q <= '0;
      end else if (busy) begin
         hold_q <= hold_q - 1'b1;
         if (hold_q == HW'(1)) cnt_q <= reload_i;
      end else if (cnt_q == '0) begin
         hold_q <= HW'(HOLD);
      end else if (refresh_i) begin
         cnt_q  <= reload_i;
      end else if (tick_i) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   p_fire_from_zero_r3: assert property (@(posedge clk_i) disable iff (!arst_ni)
      $rose(fire_o) |-> ($past(cnt_q) == '0 && $past(run_i)));

   p_reload_after_pulse_r4: assert property (@(posedge clk_i) disable iff (!arst_ni)
      $fell(fire_o) |-> (cnt_q == $past(reload_i)));

   p_hold_bound_r4: assert property (@(posedge clk_i) disable iff (!arst_ni)
      hold_q <= HW'(HOLD));

   p_step_r2: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (run_i && $past(run_i) && !$past(busy) && $past(cnt_q) != '0 && !$past(refresh_i))
      |-> (cnt_q == $past(cnt_q) - CNT_W'($past(tick_i))));

endmodule

// File: rtl/lswd_watchdog.sv
module lswd_watchdog #(
   parameter int unsigned CODE_W      = 3,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned BASE_SHIFT  = 2,
   parameter int unsigned HOLD_CYCLES = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              arst_ni,
   input  logic              enable_i,
   input  logic [CODE_W-1:0] psc_code_i,
   input  logic [CNT_W-1:0]  reload_i,
   input  logic              refresh_req_i,
   output logic              wdt_rst_o,
   output logic [CNT_W-1:0]  count_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
      if (CNT_W < 2 || CODE_W < 1) begin : g_bad_width
         $error("CNT_W must be >= 2 and CODE_W >= 1");
      end
   endgenerate

   logic en_q;
   logic tick;
   logic refresh_pulse;

   // R7: sticky start, cleared only by the asynchronous reset
   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni)      en_q <= 1'b0;
      else if (enable_i) en_q <= 1'b1;
   end

   p_sticky_en_r7: assert property (@(posedge clk_i) disable iff (!arst_ni)
      $past(en_q) |-> en_q);

   lswd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .arst_ni (arst_ni),
      .req_i   (refresh_req_i),
      .pulse_o (refresh_pulse)
   );

   lswd_prescaler #(.CODE_W(CODE_W), .BASE_SHIFT(BASE_SHIFT)) u_psc (
      .clk_i   (clk_i),
      .arst_ni (arst_ni),
      .run_i   (en_q),
      .code_i  (psc_code_i),
      .tick_o  (tick)
   );

   lswd_downcnt #(.CNT_W(CNT_W), .HOLD(HOLD_CYCLES)) u_cnt (
      .clk_i     (clk_i),
      .arst_ni   (arst_ni),
      .run_i     (en_q),
      .tick_i    (tick),
      .refresh_i (refresh_pulse),
      .reload_i  (reload_i),
      .count_o   (count_o),
      .fire_o    (wdt_rst_o)
   );

endmodule

// File: tb/lswd_watchdog_tb.sv
module lswd_watchdog_tb;

   logic        clk = 1'b0;
   logic        arst_ni = 1'b0;
   logic        enable_i = 1'b0;
   logic [2:0]  psc_code_i = '0;
   logic [11:0] reload_i = '0;
   logic        refresh_req_i = 1'b0;
   logic        wdt_rst_o;
   logic [11:0] count_o;

   int nchecks = 0;
   int nerr    = 0;
   int cycles  = 0;

   always #2 clk = ~clk;

   lswd_watchdog u_dut (
      .clk_i         (clk),
      .arst_ni       (arst_ni),
      .enable_i      (enable_i),
      .psc_code_i    (psc_code_i),
      .reload_i      (reload_i),
      .refresh_req_i (refresh_req_i),
      .wdt_rst_o     (wdt_rst_o),
      .count_o       (count_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      arst_ni       = 1'b0;
      enable_i      = 1'b0;
      refresh_req_i = 1'b0;
      #1;
      chk(wdt_rst_o == 1'b0, "R1 rst low in reset", int'(wdt_rst_o), 0);
      chk(count_o == 12'd0, "R1 count zero in reset", int'(count_o), 0);
      @(negedge clk);
      arst_ni = 1'b1;
   endtask

   // enable at edge E (n = 0); expect first reset at edge n = exp_n
   task automatic run_case(input int code, input int rl, input bit drop_en,
                           input int chg_at, input int new_code, input int exp_n);
      int  d;
      int  n;
      bit  fired;
      string tag;
      d = 4 << code;
      tag = (chg_at >= 0) ? "R8" : (drop_en ? "R7" : "R3");
      do_reset();
      psc_code_i = 3'(code);
      reload_i   = 12'(rl);
      cyc();
      cyc();
      chk(count_o == 12'(rl), "R1 count follows reload", int'(count_o), rl);
      chk(!wdt_rst_o, "R1 no reset while idle", int'(wdt_rst_o), 0);
      enable_i = 1'b1;
      cyc();
      n = 0;
      if (drop_en) enable_i = 1'b0;
      fired = 1'b0;
      while (!fired && n < 6000) begin
         if (n == chg_at) psc_code_i = 3'(new_code);
         if (chg_at < 0 && n == d - 1)
            chk(count_o == 12'(rl), "R2 count before first tick", int'(count_o), rl);
         if (chg_at < 0 && n == d)
            chk(count_o == 12'(rl - 1), "R2 count after first tick", int'(count_o), rl - 1);
         if (wdt_rst_o) fired = 1'b1;
         else begin
            cyc();
            n++;
         end
      end
      chk(n == exp_n, tag, n, exp_n);
      for (int k = 1; k < 4; k++) begin
         cyc();
         chk(wdt_rst_o == 1'b1, "R4 reset pulse held", int'(wdt_rst_o), 1);
      end
      cyc();
      chk(wdt_rst_o == 1'b0, "R4 reset pulse ends after 4", int'(wdt_rst_o), 0);
      chk(count_o == 12'(rl), "R4 reload after pulse", int'(count_o), rl);
   endtask

   initial begin
      while (1) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            nerr++;
            nchecks++;
            $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
         end
      end
   end

   initial begin
      int peak;
      bit seen;
      #1;
      chk(wdt_rst_o == 1'b0, "R1 rst low at start", int'(wdt_rst_o), 0);
      chk(count_o == 12'd0, "R1 count zero at start", int'(count_o), 0);

      // R2/R3/R4: every prescaler code, reload 2; R7: enable dropped on odd codes
      for (int c = 0; c < 8; c++)
         run_case(c, 2, c[0], -1, 0, 2 * (4 << c) + 1);

      // R3: reload sweep at divide-by-4
      for (int r = 1; r <= 6; r++)
         run_case(0, r, 1'b0, -1, 0, r * 4 + 1);

      // R8: code 2 -> 0 at edge 5; old period ends at 16, next tick at 20
      run_case(2, 2, 1'b0, 5, 0, 21);

      // R5: reload latency through the synchronizer
      do_reset();
      psc_code_i = 3'd0;
      reload_i   = 12'd200;
      cyc();
      enable_i = 1'b1;
      for (int i = 0; i < 40; i++) cyc();
      refresh_req_i = 1'b1;
      cyc();
      cyc();
      chk(count_o < 12'd200, "R5 no reload one edge after sampling", int'(count_o), 190);
      cyc();
      chk(count_o == 12'd200, "R5 reload on second edge", int'(count_o), 200);
      // R6: a request held high reloads once only
      for (int i = 0; i < 100; i++) cyc();
      chk(count_o < 12'd180, "R6 held request reloads once", int'(count_o), 175);
      refresh_req_i = 1'b0;

      // R5: periodic refresh below the 12-cycle timeout prevents reset
      do_reset();
      psc_code_i = 3'd0;
      reload_i   = 12'd3;
      cyc();
      enable_i = 1'b1;
      seen = 1'b0;
      peak = 0;
      for (int i = 0; i < 240; i++) begin
         refresh_req_i = ((i % 8) < 2);
         cyc();
         if (wdt_rst_o) seen = 1'b1;
         if (int'(count_o) > peak) peak = int'(count_o);
      end
      refresh_req_i = 1'b0;
      chk(!seen, "R5 periodic refresh avoids reset", int'(seen), 0);
      chk(peak == 3, "R5 count peaks at reload", peak, 3);

      // R9: asynchronous reset during the reset pulse
      do_reset();
      psc_code_i = 3'd0;
      reload_i   = 12'd1;
      cyc();
      enable_i = 1'b1;
      for (int i = 0; i < 7; i++) cyc();
      chk(wdt_rst_o == 1'b1, "R9 pulse active before reset", int'(wdt_rst_o), 1);
      #1;
      arst_ni = 1'b0;
      #0.5;
      chk(wdt_rst_o == 1'b0, "R9 async clear of reset request", int'(wdt_rst_o), 0);
      chk(count_o == 12'd0, "R9 async clear of counter", int'(count_o), 0);
      enable_i = 1'b0;
      @(negedge clk);
      arst_ni = 1'b1;
      cyc();
      cyc();
      chk(!wdt_rst_o, "R7 enable cleared by reset", int'(wdt_rst_o), 0);

      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   end

endmodule